// File: doc/BRIEF.md
# Game Controller Command Responder

This block stands in for a game controller on a peripheral bus. A DMA walker hands it one command at a time (a command code plus a two-bit port number) over a valid/ready handshake. The block then returns a reply as a stream of 32-bit words. The first word carries a response code and the words after it are payload. It answers four commands: a device info query, an extended info query that adds a version block, a reset, and a get-condition query. The get-condition reply reports the button state of the addressed port.

The reply content comes from a small computed ROM holding an identity block and a version block, from a fixed function word, and from the 16-bit button input of the selected port. Output words advance only when the consumer asserts ready. The final word of every reply is flagged. A reset command, or a command code the block does not recognise, is taken in a single handshake and produces no reply stream. An unrecognised code also raises a flag to the walker during that handshake.

A controller built around enumerated states runs the sequence:
- IDLE: waits for a command.
- HEAD: presents the response code.
- ID_BODY: streams the 28 identity words.
- VER_BODY: streams the 20 version words.
- FUNC: presents the function word.
- COND: presents the captured condition word.
- FILL: presents the all-ones closing word.

The transitions are:
- IDLE→HEAD on an accepted info, extended-info or condition command.
- IDLE→IDLE on an accepted reset or unrecognised command.
- HEAD→ID_BODY for the info commands.
- HEAD→FUNC for the condition command.
- ID_BODY→VER_BODY after the last identity word of an extended-info reply.
- ID_BODY→IDLE after the last identity word of a plain info reply.
- VER_BODY→IDLE after the last version word.
- FUNC→COND→FILL→IDLE.

Every transition out of a streaming state happens only on an accepted output word.

Top module: `pad_reply_engine`

## Requirements
- R1: After reset, cmd_ready is 1 and out_valid is 0.
- R2: Command code 1 gives a 29-word reply: word 0 is 0x00000005, followed by the 28 identity words in order.
- R3: Identity word w packs identity bytes 4w..4w+3, lowest byte address in bits 7:0. Bytes 0..7 are 01 00 00 00 FE 06 0F 00, bytes 108..111 are AE 01 F4 01, and every other identity byte equals its offset modulo 256. So word 0 is 0x00000001, word 1 is 0x000F06FE and word 27 is 0x01F401AE.
- R4: Command code 2 gives a 49-word reply: 0x00000006, then the 28 identity words, then 20 version words. Version byte j (0..79) is 0x40+j, packed four to a word with the lowest byte in bits 7:0.
- R5: Command code 9 gives a 4-word reply: 0x00000008, then the function word 0x01000000, then the condition word, then 0xFFFFFFFF.
- R6: The condition word is {16'hFFFF, B[15:8], B[7:0]}, where B is btn_in[16p+15:16p] for the port p given with the command. B is sampled in the cycle the function word is accepted.
- R7: Command code 3 is accepted with cmd_unknown at 0 and produces no output word. cmd_ready is 1 again in the next cycle.
- R8: Any code other than 1, 2, 3 or 9 is accepted with cmd_unknown at 1 during the handshake cycle and produces no output word.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values into the next cycle.
- R10: out_last is 1 only on the final word of a reply. cmd_ready is 0 throughout a reply and is 1 in the cycle after the final word is accepted.
- R11: cmd_unknown is 0 in any cycle without a command handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Walker offers a command |
| cmd_ready | output | 1 | Block can take a command |
| cmd_code | input | 8 | Command code |
| cmd_port | input | 2 | Port selecting the button input |
| cmd_unknown | output | 1 | Offered code is not recognised (valid on handshake) |
| out_valid | output | 1 | Reply word present |
| out_ready | input | 1 | Consumer takes the reply word |
| out_data | output | 32 | Reply word |
| out_last | output | 1 | Final word of the reply |
| btn_in | input | 64 | Four 16-bit button inputs, port p in bits 16p+15:16p |

## Verification
A wrong word counter or a wrong ROM index shows up as a miscompare on the first affected reply word. The stream is compared word by word, so the error is seen in the very cycle that word is accepted. A state register that branches the wrong way shows up as a wrong word count, a misplaced last flag, or cmd_ready failing to return one cycle after the final word. The stall pattern exposes a state or counter that advances without out_ready on the next cycle, because the held word changes.

// File: rtl/pad_reply_pkg.sv
package pad_reply_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_ID_BODY,
        ST_VER_BODY,
        ST_FUNC,
        ST_COND,
        ST_FILL
    } reply_state_t;

    localparam logic [7:0] CMD_INFO  = 8'd1;
    localparam logic [7:0] CMD_XINFO = 8'd2;
    localparam logic [7:0] CMD_RESET = 8'd3;
    localparam logic [7:0] CMD_COND  = 8'd9;

    localparam logic [31:0] RSP_INFO  = 32'd5;
    localparam logic [31:0] RSP_XINFO = 32'd6;
    localparam logic [31:0] RSP_DATA  = 32'd8;

    // Identity byte at offset i: fixed header and trailer, offset elsewhere.
    function automatic logic [7:0] id_byte(input int unsigned i);
        logic [7:0] b;
        case (i)
            0:          b = 8'h01;
            1, 2, 3, 7: b = 8'h00;
            4:          b = 8'hFE;
            5:          b = 8'h06;
            6:          b = 8'h0F;
            108:        b = 8'hAE;
            109:        b = 8'h01;
            110:        b = 8'hF4;
            111:        b = 8'h01;
            default:    b = 8'(i);
        endcase
        return b;
    endfunction

    // Version byte at offset j: ascending from 0x40.
    function automatic logic [7:0] ver_byte(input int unsigned j);
        return 8'(32'h40 + j);
    endfunction

endpackage

// File: rtl/pad_rom.sv
module pad_rom
    import pad_reply_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             sel_ver,
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      word
);
    localparam int BYTES_PER_WORD = 4;

    for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_byte
        always_comb begin
            if (sel_ver)
                word[8*b +: 8] = ver_byte(32'(idx) * BYTES_PER_WORD + b);
            else
                word[8*b +: 8] = id_byte(32'(idx) * BYTES_PER_WORD + b);
        end
    end

endmodule

// File: rtl/pad_cond_pack.sv
module pad_cond_pack #(
    parameter int PORT_W = 2,
    parameter int BTN_W  = 16
) (
    input  logic [(1<<PORT_W)*BTN_W-1:0] btn_in,
    input  logic [PORT_W-1:0]            port,
    output logic [31:0]                  cond_word
);
    localparam int HALF = BTN_W / 2;

    logic [BTN_W-1:0] sel;
    logic [HALF-1:0]  hi_byte;
    logic [HALF-1:0]  lo_byte;

    always_comb begin
        sel       = btn_in[32'(port) * BTN_W +: BTN_W];
        hi_byte   = sel[BTN_W-1:HALF];
        lo_byte   = sel[HALF-1:0];
        cond_word = {{(32-BTN_W){1'b1}}, hi_byte, lo_byte};
    end

endmodule

// File: rtl/pad_reply_engine.sv
module pad_reply_engine
    import pad_reply_pkg::*;
#(
    parameter int          ID_WORDS  = 28,
    parameter int          VER_WORDS = 20,
    parameter int          PORT_W    = 2,
    parameter int          BTN_W     = 16,
    parameter logic [31:0] FUNC_WORD = 32'h0100_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    output logic                          cmd_ready,
    input  logic [7:0]                    cmd_code,
    input  logic [PORT_W-1:0]             cmd_port,
    output logic                          cmd_unknown,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [31:0]                   out_data,
    output logic                          out_last,
    input  logic [(1<<PORT_W)*BTN_W-1:0]  btn_in
);
    localparam int MAX_WORDS = (ID_WORDS > VER_WORDS) ? ID_WORDS : VER_WORDS;
    localparam int IDX_W     = $clog2(MAX_WORDS);
    localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_WORDS - 1);
    localparam logic [IDX_W-1:0] VER_LAST = IDX_W'(VER_WORDS - 1);

    reply_state_t      state, state_nxt;
    logic [IDX_W-1:0]  idx, idx_nxt;
    logic [7:0]        cmd_q;
    logic [PORT_W-1:0] port_q;
    logic [31:0]       cond_q;
    logic [31:0]       rom_word;
    logic [31:0]       cond_word;
    logic              cmd_hs, out_hs, code_streams, code_known;

    pad_rom #(.IDX_W(IDX_W)) u_rom (
        .sel_ver (state == ST_VER_BODY),
        .idx     (idx),
        .word    (rom_word)
    );

    pad_cond_pack #(.PORT_W(PORT_W), .BTN_W(BTN_W)) u_cond (
        .btn_in    (btn_in),
        .port      (port_q),
        .cond_word (cond_word)
    );

    assign cmd_hs = cmd_valid && cmd_ready;
    assign out_hs = out_valid && out_ready;
    assign code_streams = (cmd_code == CMD_INFO) || (cmd_code == CMD_XINFO)
                       || (cmd_code == CMD_COND);
    assign code_known   = code_streams || (cmd_code == CMD_RESET);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            cmd_q  <= '0;
            port_q <= '0;
            cond_q <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
            if (cmd_hs) begin
                cmd_q  <= cmd_code;
                port_q <= cmd_port;
            end
            if (state == ST_FUNC && out_hs)
                cond_q <= cond_word;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        unique case (state)
            ST_IDLE: begin
                if (cmd_hs && code_streams)
                    state_nxt = ST_HEAD;
            end
            ST_HEAD: begin
                if (out_hs) begin
                    idx_nxt   = '0;
                    state_nxt = (cmd_q == CMD_COND) ? ST_FUNC : ST_ID_BODY;
                end
            end
            ST_ID_BODY: begin
                if (out_hs) begin
                    if (idx == ID_LAST) begin
                        idx_nxt   = '0;
                        state_nxt = (cmd_q == CMD_XINFO) ? ST_VER_BODY : ST_IDLE;
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
            end
            ST_VER_BODY: begin
                if (out_hs) begin
                    if (idx == VER_LAST) begin
                        idx_nxt   = '0;
                        state_nxt = ST_IDLE;
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
            end
            ST_FUNC: if (out_hs) state_nxt = ST_COND;
            ST_COND: if (out_hs) state_nxt = ST_FILL;
            ST_FILL: if (out_hs) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready   = (state == ST_IDLE);
        cmd_unknown = cmd_hs && !code_known;
        out_valid   = (state != ST_IDLE);
        out_data    = '0;
        out_last    = 1'b0;
        unique case (state)
            ST_IDLE: out_data = '0;
            ST_HEAD: begin
                if (cmd_q == CMD_INFO)       out_data = RSP_INFO;
                else if (cmd_q == CMD_XINFO) out_data = RSP_XINFO;
                else                         out_data = RSP_DATA;
            end
            ST_ID_BODY: begin
                out_data = rom_word;
                out_last = (idx == ID_LAST) && (cmd_q != CMD_XINFO);
            end
            ST_VER_BODY: begin
                out_data = rom_word;
                out_last = (idx == VER_LAST);
            end
            ST_FUNC: out_data = FUNC_WORD;
            ST_COND: out_data = cond_q;
            ST_FILL: begin
                out_data = '1;
                out_last = 1'b1;
            end
            default: out_data = '0;
        endcase
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (cmd_ready && !out_valid));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R10
    ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (cmd_ready && !out_valid));

    // R5
    cond_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_code == CMD_COND) |=> (out_valid && out_data == RSP_DATA));

    // R7
    reset_cmd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_code == CMD_RESET) |=> (cmd_ready && !out_valid));

    // R11
    unknown_on_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_unknown |-> (cmd_valid && cmd_ready));

    // R6
    cond_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COND) |-> (out_data[31:16] == 16'hFFFF));

endmodule

// File: tb/pad_reply_engine_tb.sv
module pad_reply_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [7:0]  cmd_code;
    logic [1:0]  cmd_port;
    logic        cmd_unknown;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_data;
    logic        out_last;
    logic [63:0] btn_in;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pad_reply_engine u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_code    (cmd_code),
        .cmd_port    (cmd_port),
        .cmd_unknown (cmd_unknown),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_last    (out_last),
        .btn_in      (btn_in)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // R3: identity bytes
    function automatic logic [7:0] id_b(input int i);
        case (i)
            0: return 8'h01;
            1, 2, 3, 7: return 8'h00;
            4: return 8'hFE;
            5: return 8'h06;
            6: return 8'h0F;
            108: return 8'hAE;
            109: return 8'h01;
            110: return 8'hF4;
            111: return 8'h01;
            default: return 8'(i);
        endcase
    endfunction

    function automatic logic [31:0] id_w(input int w);
        return {id_b(4*w+3), id_b(4*w+2), id_b(4*w+1), id_b(4*w)};
    endfunction

    // R4: version bytes
    function automatic logic [31:0] ver_w(input int w);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = 8'(8'h40 + 4*w + b);
        return r;
    endfunction

    function automatic int exp_len(input logic [7:0] c);
        if (c == 8'd1) return 29;
        if (c == 8'd2) return 49;
        return 4;
    endfunction

    function automatic logic [31:0] exp_word(input logic [7:0] c, input logic [1:0] p, input int k);
        if (c == 8'd9) begin
            case (k)
                0: return 32'd8;
                1: return 32'h0100_0000;
                2: return {16'hFFFF, btn_in[16*p + 8 +: 8], btn_in[16*p +: 8]};
                default: return 32'hFFFF_FFFF;
            endcase
        end
        if (k == 0) return (c == 8'd1) ? 32'd5 : 32'd6;
        if (k <= 28) return id_w(k - 1);
        return ver_w(k - 29);
    endfunction

    function automatic string tag_of(input logic [7:0] c, input int k);
        if (c == 8'd9) return (k == 2) ? "R6" : "R5";
        if (c == 8'd2) return "R4";
        return (k == 0) ? "R2" : "R3";
    endfunction

    // Offer one command; starts and ends just after a falling edge.
    task automatic issue(input logic [7:0] c, input logic [1:0] p, input bit exp_unk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        cmd_port  = p;
        #1;
        chk(cmd_ready === 1'b1, "R10 ready before command", 32'(cmd_ready), 32'd1);
        chk(cmd_unknown === exp_unk, exp_unk ? "R8 unknown flag" : "R7 unknown flag",
            32'(cmd_unknown), 32'(exp_unk));
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Consume and check one reply stream.
    task automatic collect(input logic [7:0] c, input logic [1:0] p, input bit stall);
        int n = exp_len(c);
        int k = 0;
        int cyc = 0;
        bit pend = 1'b0;
        logic [31:0] held = '0;
        logic held_last = 1'b0;
        while (k < n && cyc < 400) begin
            out_ready = stall ? (cyc % 3 != 2) : 1'b1;
            #1;
            if (pend) begin
                chk(out_data === held, "R9 data held", out_data, held);
                chk(out_last === held_last, "R9 last held", 32'(out_last), 32'(held_last));
            end
            pend = 1'b0;
            chk(out_valid === 1'b1, "R10 valid during reply", 32'(out_valid), 32'd1);
            if (k == 0)
                chk(cmd_ready === 1'b0, "R10 busy during reply", 32'(cmd_ready), 32'd0);
            if (out_ready) begin
                chk(out_data === exp_word(c, p, k), tag_of(c, k), out_data, exp_word(c, p, k));
                chk(out_last === (k == n - 1), "R10 last flag", 32'(out_last), 32'(k == n - 1));
                k++;
            end else begin
                held = out_data;
                held_last = out_last;
                pend = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        #1;
        chk(cmd_ready === 1'b1 && out_valid === 1'b0, "R10 idle after last",
            {30'd0, cmd_ready, out_valid}, 32'd2);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(cmd_ready === 1'b1, "R1 ready after reset", 32'(cmd_ready), 32'd1);
        chk(out_valid === 1'b0, "R1 no output after reset", 32'(out_valid), 32'd0);
        @(negedge clk);
    endtask

    task automatic t_idle_flag();
        cmd_valid = 1'b0;
        cmd_code  = 8'h55;
        #1;
        chk(cmd_unknown === 1'b0, "R11 no flag without handshake", 32'(cmd_unknown), 32'd0);
        @(negedge clk);
    endtask

    task automatic t_info(input bit stall);
        issue(8'd1, 2'd2, 1'b0);
        collect(8'd1, 2'd2, stall);
    endtask

    task automatic t_xinfo(input bit stall);
        issue(8'd2, 2'd0, 1'b0);
        collect(8'd2, 2'd0, stall);
    endtask

    task automatic t_cond(input logic [1:0] p, input bit stall);
        issue(8'd9, p, 1'b0);
        collect(8'd9, p, stall);
    endtask

    task automatic t_silent(input logic [7:0] c, input bit unk);
        issue(c, 2'd1, unk);
        #1;
        chk(out_valid === 1'b0, unk ? "R8 no reply" : "R7 no reply", 32'(out_valid), 32'd0);
        chk(cmd_ready === 1'b1, unk ? "R8 ready again" : "R7 ready again", 32'(cmd_ready), 32'd1);
        @(negedge clk);
        chk(out_valid === 1'b0, unk ? "R8 still silent" : "R7 still silent", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cmd_valid = 1'b0;
        cmd_code  = '0;
        cmd_port  = '0;
        out_ready = 1'b0;
        btn_in    = {16'hA55A, 16'h0F0F, 16'h1234, 16'hC381};
        rst_n     = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_flag();
        t_info(1'b0);
        t_info(1'b1);
        t_xinfo(1'b0);
        t_xinfo(1'b1);
        for (int p = 0; p < 4; p++) t_cond(2'(p), p[0]);
        btn_in = {16'h00FF, 16'hFF00, 16'h8001, 16'h7E7E};
        for (int p = 0; p < 4; p++) t_cond(2'(p), 1'b1);
        t_silent(8'd3, 1'b0);
        t_silent(8'd0, 1'b1);
        t_silent(8'd4, 1'b1);
        t_silent(8'hFF, 1'b1);
        t_idle_flag();
        t_cond(2'd3, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule